// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is the bus-facing command interpreter of a parallel NOR flash that speaks the classic two-cycle command set. It fronts a small byte-wide storage array built from registers. Every bus write is either a command byte or a data/argument byte. Which one it is depends on the write-cycle phase and on the command already latched. The block keeps that phase and command, and from them chooses what a bus read returns: array bytes, the status byte, identifier codes or query-table bytes.

A host drives single-cycle write strobes and read strobes. Read data is registered and appears one clock after the read strobe. It reflects the state at the strobe edge. The sequences are byte program, sector erase with confirm, buffered write with a word count, lock/unlock, status clear, status read, identify, query and the return to array reading. Program and erase complete at once: no busy time is modelled. A write-protect input turns stores and erases into sticky error flags in the status byte.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, reads return array bytes, every array byte is 0xFF, the phase is the command phase, and the status byte is 0x80 (bit 7 = ready).
- R2: A read strobe in array mode returns the addressed byte on rdData exactly one clock later.
- R3: Writing 0x10 or 0x40 in the command phase and then a data byte stores that byte at the second write's address. It sets status bit 7 and returns to the command phase. After 0xFF the stored byte reads back.
- R4: With wrProtect high, the program data write leaves the array unchanged and sets status bit 4 (program error) together with bit 7.
- R5: Writing 0x20 in the command phase at once sets every byte of the sector that holds the address to 0xFF. The sector base is the address with its low log2(sector size) bits cleared. Other sectors are untouched. A following 0xD0 returns to the command phase with bit 7 set. Any other following byte returns to array mode.
- R6: A 0x20 written while wrProtect is high erases nothing and sets status bits 5 (erase error) and 7.
- R7: Buffered write: 0xE8, then a count N, then N+1 data writes that each store one byte, then 0xD0 returns to the command phase with bit 7 set. A non-0xD0 confirm returns to array mode, and the data already written stays.
- R8: 0x50 in the command phase sets the status byte to 0x00 and returns to array mode.
- R9: 0x70 latches without advancing the phase. While the latched command is 0x10, 0x20, 0x28, 0x40, 0x50, 0x60, 0x70 or 0xE8, reads return the status byte.
- R10: After 0x90, a read at offset 0 returns MFR_ID, offset 1 returns DEV_ID, and any other offset returns 0x00.
- R11: After 0x98, reads return the query table (offsets 0x10, 0x11, 0x12 give 0x51, 0x52, 0x59). Further writes other than 0xFF keep query mode, and 0xFF leaves it.
- R12: 0x60 followed by 0xD0 or 0x01 completes with status readable and bit 7 set. Followed by any other byte it returns to array mode.
- R13: 0xFF, 0xF0 and 0x00 in the command phase select array mode. An unrecognised command byte also returns to array mode and leaves the array and status unchanged.
- R14: Status bits 4 and 5 are sticky: only 0x50 or reset clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wrData | input | 8 | Command or data byte of a write |
| wrProtect | input | 1 | Array write protection |
| rdData | output | 8 | Registered read result, valid one clock after rdEn |

## Verification
The assertions check the phase and command transitions on every cycle. These are status clear, status-read latching, buffered-write confirm, query-mode hold and the error flags raised under protection, including their stickiness. Only the bench scenarios can show what the array holds: sector-wide erase boundaries, buffered data landing at the right addresses, protected writes leaving bytes intact, and program readback against a reference model. The read mux contents are also shown only there: identifier and query bytes, and status in place of array data.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    CYC_CMD     = 2'd0,
    CYC_ARG     = 2'd1,
    CYC_DATA    = 2'd2,
    CYC_CONFIRM = 2'd3
  } cycle_e;

  typedef enum logic [1:0] {
    SEL_ARRAY  = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_IDENT  = 2'd2,
    SEL_QUERY  = 2'd3
  } rdSel_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic memWr;
    logic eraseSec;
    logic loadCnt;
    logic cntDec;
    logic statClear;
    logic setReady;
    logic setProgErr;
    logic setEraseErr;
  } strobe_t;

  localparam logic [7:0] OP_NULL      = 8'h00;
  localparam logic [7:0] OP_LOCK_ALT  = 8'h01;
  localparam logic [7:0] OP_PROG_A    = 8'h10;
  localparam logic [7:0] OP_ERASE     = 8'h20;
  localparam logic [7:0] OP_ERASE_ALT = 8'h28;
  localparam logic [7:0] OP_PROG_B    = 8'h40;
  localparam logic [7:0] OP_CLR_STAT  = 8'h50;
  localparam logic [7:0] OP_LOCK      = 8'h60;
  localparam logic [7:0] OP_STATUS    = 8'h70;
  localparam logic [7:0] OP_IDENT     = 8'h90;
  localparam logic [7:0] OP_QUERY     = 8'h98;
  localparam logic [7:0] OP_CONFIRM   = 8'hD0;
  localparam logic [7:0] OP_BUF       = 8'hE8;
  localparam logic [7:0] OP_ALT_RESET = 8'hF0;
  localparam logic [7:0] OP_READ      = 8'hFF;

  function automatic logic [7:0] queryByte(input logic [7:0] idx,
                                           input int unsigned sizeLog2,
                                           input int unsigned sectors);
    logic [7:0] res;
    case (idx)
      8'h10:   res = 8'h51;
      8'h11:   res = 8'h52;
      8'h12:   res = 8'h59;
      8'h13:   res = 8'h01;
      8'h27:   res = 8'(sizeLog2);
      8'h2C:   res = 8'h01;
      8'h2D:   res = 8'(sectors - 1);
      default: res = 8'h00;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       wrProtect,
  input  logic       cntZero,
  output strobe_t    strb,
  output cycle_e     cycState,
  output logic [7:0] cmdState,
  output rdSel_e     rdSel
);

  cycle_e     cycNxt;
  logic [7:0] cmdNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycState <= CYC_CMD;
      cmdState <= OP_NULL;
    end else begin
      cycState <= cycNxt;
      cmdState <= cmdNxt;
    end
  end

  always_comb begin
    strb   = '0;
    cycNxt = cycState;
    cmdNxt = cmdState;
    if (wrEn) begin
      unique case (cycState)
        CYC_CMD: begin
          case (wrData)
            OP_READ, OP_ALT_RESET, OP_NULL: begin
              cmdNxt = OP_NULL;
              cycNxt = CYC_CMD;
            end
            OP_CLR_STAT: begin
              strb.statClear = 1'b1;
              cmdNxt = OP_NULL;
              cycNxt = CYC_CMD;
            end
            OP_STATUS, OP_IDENT: cmdNxt = wrData;
            OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
              cmdNxt = wrData;
              cycNxt = CYC_ARG;
            end
            OP_ERASE: begin
              strb.eraseSec    = !wrProtect;
              strb.setEraseErr = wrProtect;
              strb.setReady    = 1'b1;
              cmdNxt = wrData;
              cycNxt = CYC_ARG;
            end
            OP_BUF: begin
              strb.setReady = 1'b1;
              cmdNxt = wrData;
              cycNxt = CYC_ARG;
            end
            default: begin
              cmdNxt = OP_NULL;
              cycNxt = CYC_CMD;
            end
          endcase
        end
        CYC_ARG: begin
          case (cmdState)
            OP_PROG_A, OP_PROG_B: begin
              strb.memWr      = !wrProtect;
              strb.setProgErr = wrProtect;
              strb.setReady   = 1'b1;
              cycNxt = CYC_CMD;
            end
            OP_ERASE, OP_ERASE_ALT: begin
              if (wrData == OP_CONFIRM) begin
                strb.setReady = 1'b1;
                cycNxt = CYC_CMD;
              end else begin
                cmdNxt = OP_NULL;
                cycNxt = CYC_CMD;
              end
            end
            OP_BUF: begin
              strb.loadCnt = 1'b1;
              cycNxt = CYC_DATA;
            end
            OP_LOCK: begin
              if (wrData == OP_CONFIRM || wrData == OP_LOCK_ALT) begin
                strb.setReady = 1'b1;
                cycNxt = CYC_CMD;
              end else begin
                cmdNxt = OP_NULL;
                cycNxt = CYC_CMD;
              end
            end
            OP_QUERY: begin
              if (wrData == OP_READ) begin
                cmdNxt = OP_NULL;
                cycNxt = CYC_CMD;
              end
            end
            default: begin
              cmdNxt = OP_NULL;
              cycNxt = CYC_CMD;
            end
          endcase
        end
        CYC_DATA: begin
          if (cmdState == OP_BUF) begin
            strb.memWr      = !wrProtect;
            strb.setProgErr = wrProtect;
            strb.setReady   = 1'b1;
            strb.cntDec     = 1'b1;
            if (cntZero) cycNxt = CYC_CONFIRM;
          end else begin
            cmdNxt = OP_NULL;
            cycNxt = CYC_CMD;
          end
        end
        CYC_CONFIRM: begin
          if (cmdState == OP_BUF && wrData == OP_CONFIRM) begin
            strb.setReady = 1'b1;
            cycNxt = CYC_CMD;
          end else begin
            cmdNxt = OP_NULL;
            cycNxt = CYC_CMD;
          end
        end
      endcase
    end
  end

  always_comb begin
    case (cmdState)
      OP_IDENT: rdSel = SEL_IDENT;
      OP_QUERY: rdSel = SEL_QUERY;
      OP_PROG_A, OP_PROG_B, OP_ERASE, OP_ERASE_ALT,
      OP_CLR_STAT, OP_LOCK, OP_STATUS, OP_BUF: rdSel = SEL_STATUS;
      default: rdSel = SEL_ARRAY;
    endcase
  end

endmodule

// File: rtl/flash_cmd_dpath.sv
module flash_cmd_dpath
  import flash_cmd_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES = 64,
  parameter int unsigned NUM_SECTORS  = 4,
  parameter logic [7:0]  MFR_ID       = 8'h89,
  parameter logic [7:0]  DEV_ID       = 8'h18,
  localparam int unsigned DEPTH  = SECTOR_BYTES * NUM_SECTORS,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned SEC_W  = $clog2(SECTOR_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  rdSel_e            rdSel,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic              cntZero,
  output logic [7:0]        statusState,
  output logic [7:0]        rdData
);

  logic [DEPTH-1:0][7:0] memArr;
  logic [7:0]            cntReg;
  logic [ADDR_W-1:0]     secBase;

  assign secBase = (addr >> SEC_W) << SEC_W;
  assign cntZero = (cntReg == 8'h00);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam logic [ADDR_W-1:0] CELL_BASE = ADDR_W'((g / SECTOR_BYTES) * SECTOR_BYTES);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        memArr[g] <= 8'hFF;
      end else if (strb.eraseSec && secBase == CELL_BASE) begin
        memArr[g] <= 8'hFF;
      end else if (strb.memWr && addr == ADDR_W'(g)) begin
        memArr[g] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusState <= 8'h80;
    end else if (strb.statClear) begin
      statusState <= 8'h00;
    end else begin
      statusState <= statusState |
                     {strb.setReady, 1'b0, strb.setEraseErr, strb.setProgErr, 4'b0000};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg <= 8'h00;
    end else if (strb.loadCnt) begin
      cntReg <= wrData;
    end else if (strb.cntDec) begin
      cntReg <= cntReg - 8'd1;
    end
  end

  logic [7:0] rdNxt;
  always_comb begin
    unique case (rdSel)
      SEL_ARRAY:  rdNxt = memArr[addr];
      SEL_STATUS: rdNxt = statusState;
      SEL_IDENT:  rdNxt = (addr == ADDR_W'(0)) ? MFR_ID :
                          (addr == ADDR_W'(1)) ? DEV_ID : 8'h00;
      SEL_QUERY:  rdNxt = queryByte(8'(addr), ADDR_W, NUM_SECTORS);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= 8'h00;
    end else if (rdEn) begin
      rdData <= rdNxt;
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES = 64,
  parameter int unsigned NUM_SECTORS  = 4,
  parameter logic [7:0]  MFR_ID       = 8'h89,
  parameter logic [7:0]  DEV_ID       = 8'h18,
  localparam int unsigned ADDR_W = $clog2(SECTOR_BYTES * NUM_SECTORS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              wrProtect,
  output logic [7:0]        rdData
);

  strobe_t    strb;
  cycle_e     cycState;
  logic [7:0] cmdState;
  logic [7:0] statusState;
  rdSel_e     rdSel;
  logic       cntZero;

  flash_cmd_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .wrProtect(wrProtect),
    .cntZero  (cntZero),
    .strb     (strb),
    .cycState (cycState),
    .cmdState (cmdState),
    .rdSel    (rdSel)
  );

  flash_cmd_dpath #(
    .SECTOR_BYTES(SECTOR_BYTES),
    .NUM_SECTORS (NUM_SECTORS),
    .MFR_ID      (MFR_ID),
    .DEV_ID      (DEV_ID)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rdSel      (rdSel),
    .rdEn       (rdEn),
    .addr       (addr),
    .wrData     (wrData),
    .cntZero    (cntZero),
    .statusState(statusState),
    .rdData     (rdData)
  );

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       wrProtect,
  input cycle_e     cyc,
  input logic [7:0] cmd,
  input logic [7:0] status
);

  // R8
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cyc == CYC_CMD && wrData == 8'h50) |=> (status == 8'h00 && cmd == 8'h00));

  // R7
  buf_confirm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cyc == CYC_CONFIRM && cmd == 8'hE8 && wrData == 8'hD0) |=> (cyc == CYC_CMD && status[7]));

  // R6
  erase_prot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cyc == CYC_CMD && wrData == 8'h20 && wrProtect) |=> (status[5] && status[7]));

  // R4
  prog_prot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cyc == CYC_ARG && (cmd == 8'h10 || cmd == 8'h40) && wrProtect) |=> (status[4] && status[7]));

  // R9
  status_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cyc == CYC_CMD && wrData == 8'h70) |=> (cyc == CYC_CMD && cmd == 8'h70));

  // R14
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status[4] && !(wrEn && cyc == CYC_CMD && wrData == 8'h50)) |=> status[4]);

  // R11
  query_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cyc == CYC_ARG && cmd == 8'h98 && wrData != 8'hFF) |=> (cmd == 8'h98 && cyc == CYC_ARG));

endmodule

bind flash_cmd_seq flash_cmd_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .wrProtect(wrProtect),
  .cyc      (cycState),
  .cmd      (cmdState),
  .status   (statusState)
);

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic       wrProtect = 1'b0;
  logic [7:0] rdData;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  flash_cmd_seq dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .wrProtect(wrProtect), .rdData(rdData)
  );

  // vector: {isRead, addr, data-or-expected, requirement number}
  localparam int NV = 59;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 8'h05, 8'hFF, 4'd1},   // R1 erased after reset
    {1'b0, 8'h00, 8'h40, 4'd3},   // R3
    {1'b0, 8'h05, 8'h3C, 4'd3},
    {1'b1, 8'h05, 8'h80, 4'd9},   // R9 status shown after program
    {1'b0, 8'h00, 8'hFF, 4'd13},
    {1'b1, 8'h05, 8'h3C, 4'd2},   // R2 read latency
    {1'b0, 8'h00, 8'h10, 4'd3},
    {1'b0, 8'h41, 8'hA5, 4'd3},
    {1'b0, 8'h00, 8'hFF, 4'd13},
    {1'b1, 8'h41, 8'hA5, 4'd3},
    {1'b0, 8'h00, 8'h90, 4'd10},  // R10
    {1'b1, 8'h00, 8'h89, 4'd10},
    {1'b1, 8'h01, 8'h18, 4'd10},
    {1'b1, 8'h02, 8'h00, 4'd10},
    {1'b0, 8'h00, 8'hFF, 4'd13},
    {1'b0, 8'h00, 8'h98, 4'd11},  // R11
    {1'b1, 8'h10, 8'h51, 4'd11},
    {1'b1, 8'h11, 8'h52, 4'd11},
    {1'b1, 8'h12, 8'h59, 4'd11},
    {1'b0, 8'h00, 8'h33, 4'd11},
    {1'b1, 8'h10, 8'h51, 4'd11},
    {1'b0, 8'h00, 8'hFF, 4'd11},
    {1'b1, 8'h05, 8'h3C, 4'd11},
    {1'b0, 8'h47, 8'h20, 4'd5},   // R5 erase sector 0x40..0x7F
    {1'b0, 8'h47, 8'hD0, 4'd5},
    {1'b1, 8'h00, 8'h80, 4'd5},
    {1'b0, 8'h00, 8'hFF, 4'd5},
    {1'b1, 8'h41, 8'hFF, 4'd5},
    {1'b1, 8'h05, 8'h3C, 4'd5},
    {1'b0, 8'h80, 8'hE8, 4'd7},   // R7 buffered, count 2
    {1'b0, 8'h80, 8'h02, 4'd7},
    {1'b0, 8'h80, 8'h11, 4'd7},
    {1'b0, 8'h81, 8'h22, 4'd7},
    {1'b0, 8'h82, 8'h33, 4'd7},
    {1'b0, 8'h80, 8'hD0, 4'd7},
    {1'b1, 8'h80, 8'h80, 4'd7},
    {1'b0, 8'h00, 8'hFF, 4'd7},
    {1'b1, 8'h80, 8'h11, 4'd7},
    {1'b1, 8'h81, 8'h22, 4'd7},
    {1'b1, 8'h82, 8'h33, 4'd7},
    {1'b0, 8'h00, 8'h60, 4'd12},  // R12
    {1'b0, 8'h00, 8'h01, 4'd12},
    {1'b1, 8'h00, 8'h80, 4'd12},
    {1'b0, 8'h00, 8'h60, 4'd12},
    {1'b0, 8'h00, 8'h55, 4'd12},
    {1'b1, 8'h05, 8'h3C, 4'd12},
    {1'b0, 8'h00, 8'h50, 4'd8},   // R8
    {1'b0, 8'h00, 8'h70, 4'd8},
    {1'b1, 8'h00, 8'h00, 4'd8},
    {1'b0, 8'h00, 8'hFF, 4'd8},
    {1'b0, 8'h00, 8'h33, 4'd13},  // R13 unknown command
    {1'b1, 8'h05, 8'h3C, 4'd13},
    {1'b0, 8'hC0, 8'h20, 4'd5},   // R5 bad confirm
    {1'b0, 8'hC0, 8'h44, 4'd5},
    {1'b1, 8'hC0, 8'hFF, 4'd5},
    {1'b0, 8'h00, 8'h70, 4'd9},
    {1'b1, 8'h33, 8'h80, 4'd9},
    {1'b0, 8'h00, 8'h00, 4'd13},
    {1'b1, 8'h41, 8'hFF, 4'd13}
  };

  task automatic doWr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    total++;
    if (rdData !== exp) begin
      bad++;
      $display("FAIL %s addr=%h got=%h exp=%h", tag, a, rdData, exp);
    end
  endtask

  logic [7:0] model [256];

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20])
        doRd(VEC[i][19:12], VEC[i][11:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
      else
        doWr(VEC[i][19:12], VEC[i][11:4]);
    end

    // R4 protected program
    wrProtect = 1'b1;
    doWr(8'h00, 8'h50);
    doWr(8'h05, 8'h40);
    doWr(8'h05, 8'h00);
    doRd(8'h05, 8'h90, "R4 status");
    doWr(8'h00, 8'hFF);
    doRd(8'h05, 8'h3C, "R4 array kept");
    // R6 protected erase
    doWr(8'h05, 8'h20);
    doRd(8'h05, 8'hB0, "R6 status");
    doWr(8'h05, 8'hD0);
    doWr(8'h00, 8'hFF);
    doRd(8'h05, 8'h3C, "R6 array kept");
    // R14 sticky until clear
    doWr(8'h00, 8'h70);
    doRd(8'h00, 8'hB0, "R14 sticky");
    doWr(8'h00, 8'h50);
    doWr(8'h00, 8'h70);
    doRd(8'h00, 8'h00, "R14 cleared");
    doWr(8'h00, 8'hFF);
    wrProtect = 1'b0;

    // R7 abort keeps data
    doWr(8'hA0, 8'hE8);
    doWr(8'hA0, 8'h00);
    doWr(8'hA0, 8'h77);
    doWr(8'hA0, 8'h12);
    doRd(8'hA0, 8'h77, "R7 abort");

    // R1 reset mid-sequence
    doWr(8'h00, 8'h40);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    doRd(8'h05, 8'hFF, "R1 array");
    doWr(8'h00, 8'h70);
    doRd(8'h00, 8'h80, "R1 status");
    doWr(8'h00, 8'hFF);

    // R3 program readback against model
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    for (int i = 0; i < 24; i++) begin
      logic [7:0] a;
      a = 8'((i * 37 + 3) % 256);
      model[a] = 8'((i * 13 + 7) % 256);
      doWr(8'h00, (i % 2 == 0) ? 8'h10 : 8'h40);
      doWr(a, model[a]);
    end
    doWr(8'h00, 8'hFF);
    for (int i = 0; i < 24; i++) begin
      logic [7:0] a;
      a = 8'((i * 37 + 3) % 256);
      doRd(a, model[a], "R3 model");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule